// File: doc/BRIEF.md
# Recirculating Shuffle-Exchange Router

This block steers one address tag across a single-stage interconnect of N = 2^n processing elements, where n is the parameter `ADDR_W`. A message is launched with a source and a destination address. The router then changes the current address by one routing primitive per clock until it equals the destination. It shows every primitive on a per-cycle step code, and when it stops it pulses `done` together with the number of primitives used.

The main mode uses only two primitives. The perfect shuffle rotates the address left by one bit, and the exchange complements bit 0. Destination bits are settled from the most significant down, so the route needs at most 2n−1 steps. Two comparison modes change the address with one cube or one plus-minus-2^i step per cycle instead. Each of these reaches the destination within n steps.

A controller pulses `start` while the block is idle and waits for `done`. A new message may be launched in the same cycle as the `done` pulse.

Top module: `sx_route`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, `busy` and `done` are 0, `cur_addr` is 0, `step_code` is 0 and `step_total` is 0.
- R2: `start` is taken only when `busy` is 0. In the next cycle `busy` is 1 and `cur_addr` equals `src`. A `start` seen while `busy` is 1 has no effect on the running route, on its final address or on its step count.
- R3: `step_code` encodes the primitive applied at the coming clock edge: 0 none, 1 shuffle, 2 exchange, 3 cube flip, 4 add 2^i, 5 subtract 2^i. It is non-zero only while `busy` is 1, and it is non-zero in exactly `step_total` cycles of a route.
- R4: A shuffle step turns `cur_addr` into its left rotation by one bit (for n = 3, 011 becomes 110). An exchange step complements bit 0 of `cur_addr`.
- R5: In shuffle-exchange mode (`mode` 0, and also the spare code 3), the route ends with `cur_addr` equal to `dst` after at most 2n−1 steps. Destination bits are handled from the most significant down: an exchange is made if the low bit differs from the destination bit, then a shuffle is made, except for the last bit. The route ends early if the address already matches.
- R6: From the all-zeros address to the all-ones address in shuffle-exchange mode, the route alternates exchange and shuffle. It uses exactly n exchanges and n−1 shuffles, and for n = 3 the addresses after each step are 1, 2, 3, 6, 7.
- R7: A route whose source equals its destination makes no step and reports a count of 0.
- R8: In cube mode (`mode` 1), each step complements the lowest bit in which `cur_addr` differs from `dst`. The count equals the number of bits in which source and destination differ.
- R9: In plus-minus mode (`mode` 2), each step adds or subtracts one power of two modulo N. The route ends at `dst` within n steps, and a subtract step is used only when `PM_SIGNED` is 1.
- R10: `done` is a one-cycle pulse in the cycle after the last step, with `busy` 0 in that cycle. `step_total` holds the route's count from then until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a message (taken only when idle) |
| mode | input | 2 | Routing mode: 0 shuffle-exchange, 1 cube, 2 plus-minus, 3 shuffle-exchange |
| src | input | ADDR_W | Source address |
| dst | input | ADDR_W | Destination address |
| busy | output | 1 | A route is in progress |
| cur_addr | output | ADDR_W | Current address of the message |
| step_code | output | 3 | Primitive applied at the coming edge |
| done | output | 1 | One-cycle pulse when the route has finished |
| step_total | output | CNT_W | Step count of the last finished route |

## Verification
The end of one route and the launch of the next can fall in the same cycle. The bench drives `start` for the following message in the very cycle in which `done` is high, so every sweep route after the first is launched back to back. It judges that the ending route's `step_total` is correct and stays held, that `busy` is low during the pulse, and that the new route begins from its own source on the next cycle. A second overlap, `start` arriving mid-route, is provoked with a conflicting source and mode and judged by the unchanged final address and count.

// File: rtl/sx_pkg.sv
package sx_pkg;
   typedef enum logic [2:0] {
      STEP_NONE = 3'd0,
      STEP_SHUF = 3'd1,
      STEP_EXCH = 3'd2,
      STEP_CUBE = 3'd3,
      STEP_PADD = 3'd4,
      STEP_PSUB = 3'd5
   } step_e;

   typedef enum logic [1:0] {
      RT_SHEX = 2'd0,
      RT_CUBE = 2'd1,
      RT_PM   = 2'd2,
      RT_ALT  = 2'd3
   } rmode_e;
endpackage

// File: rtl/sx_se_pick.sv
// One shuffle-exchange decision: settle destination bit (W-1-ph) in the low bit,
// then rotate it upward.
module sx_se_pick #(
   parameter int W    = 3,
   parameter int PH_W = 2
) (
   input  logic [W-1:0]    cur,
   input  logic [W-1:0]    dst,
   input  logic [PH_W-1:0] ph,
   output logic [W-1:0]    nxt,
   output sx_pkg::step_e   code,
   output logic            adv
);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(W - 1);

   logic tgt;

   always_comb begin
      tgt = 1'b0;
      for (int k = 0; k < W; k++) begin
         if (PH_W'(k) == ph) tgt = dst[W-1-k];
      end
   end

   always_comb begin
      nxt  = cur;
      code = sx_pkg::STEP_NONE;
      adv  = 1'b0;
      if (cur[0] != tgt) begin
         nxt  = {cur[W-1:1], ~cur[0]};
         code = sx_pkg::STEP_EXCH;
      end else if (ph != LAST_PH) begin
         nxt  = {cur[W-2:0], cur[W-1]};
         code = sx_pkg::STEP_SHUF;
         adv  = 1'b1;
      end
   end
endmodule

// File: rtl/sx_cube_pick.sv
// One cube step: complement the lowest differing dimension.
module sx_cube_pick #(
   parameter int W = 3
) (
   input  logic [W-1:0]  cur,
   input  logic [W-1:0]  dst,
   output logic [W-1:0]  nxt,
   output sx_pkg::step_e code
);
   logic [W-1:0] diff;
   logic [W-1:0] low;

   always_comb begin
      diff = cur ^ dst;
      low  = diff & (~diff + W'(1));
      nxt  = cur ^ low;
      code = (diff != '0) ? sx_pkg::STEP_CUBE : sx_pkg::STEP_NONE;
   end
endmodule

// File: rtl/sx_pm_pick.sv
// One plus-minus-2^i step. The signed variant picks the direction whose
// remaining distance has fewer set bits.
module sx_pm_pick #(
   parameter int W      = 3,
   parameter bit SIGNED = 1'b1
) (
   input  logic [W-1:0]  cur,
   input  logic [W-1:0]  dst,
   output logic [W-1:0]  nxt,
   output sx_pkg::step_e code
);
   logic [W-1:0] up_d;
   logic [W-1:0] dn_d;
   logic [W-1:0] up_low;
   logic [W-1:0] dn_low;
   logic         use_dn;

   assign up_d   = dst - cur;
   assign dn_d   = cur - dst;
   assign up_low = up_d & (~up_d + W'(1));
   assign dn_low = dn_d & (~dn_d + W'(1));

   if (SIGNED) begin : g_signed
      assign use_dn = ($countones(dn_d) < $countones(up_d));
   end else begin : g_add_only
      assign use_dn = 1'b0;
   end

   always_comb begin
      if (up_d == '0) begin
         nxt  = cur;
         code = sx_pkg::STEP_NONE;
      end else if (use_dn) begin
         nxt  = cur - dn_low;
         code = sx_pkg::STEP_PSUB;
      end else begin
         nxt  = cur + up_low;
         code = sx_pkg::STEP_PADD;
      end
   end
endmodule

// File: rtl/sx_route.sv
module sx_route #(
   parameter int  ADDR_W    = 3,
   parameter bit  PM_SIGNED = 1'b1,
   localparam int CNT_W     = $clog2(2 * ADDR_W),
   localparam int PH_W      = $clog2(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [2:0]        step_code,
   output logic              done,
   output logic [CNT_W-1:0]  step_total
);
   import sx_pkg::*;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_width
      $error("sx_route: ADDR_W must lie in 2..16");
   end

   logic              busy_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] dst_q;
   rmode_e            mode_q;
   logic [PH_W-1:0]   ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   logic [CNT_W-1:0]  total_q;

   logic [ADDR_W-1:0] se_nxt, cb_nxt, pm_nxt, sel_nxt;
   step_e             se_code, cb_code, pm_code, sel_code;
   logic              se_adv;
   logic              arrived;
   logic              is_se;

   sx_se_pick #(.W(ADDR_W), .PH_W(PH_W)) u_se (
      .cur(cur_q), .dst(dst_q), .ph(ph_q),
      .nxt(se_nxt), .code(se_code), .adv(se_adv)
   );

   sx_cube_pick #(.W(ADDR_W)) u_cube (
      .cur(cur_q), .dst(dst_q), .nxt(cb_nxt), .code(cb_code)
   );

   sx_pm_pick #(.W(ADDR_W), .SIGNED(PM_SIGNED)) u_pm (
      .cur(cur_q), .dst(dst_q), .nxt(pm_nxt), .code(pm_code)
   );

   assign arrived = (cur_q == dst_q);
   assign is_se   = (mode_q == RT_SHEX) || (mode_q == RT_ALT);

   always_comb begin
      unique case (mode_q)
         RT_CUBE: begin sel_nxt = cb_nxt; sel_code = cb_code; end
         RT_PM:   begin sel_nxt = pm_nxt; sel_code = pm_code; end
         default: begin sel_nxt = se_nxt; sel_code = se_code; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cur_q   <= '0;
         dst_q   <= '0;
         mode_q  <= RT_SHEX;
         ph_q    <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         total_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               cur_q  <= src;
               dst_q  <= dst;
               mode_q <= rmode_e'(mode);
               ph_q   <= '0;
               cnt_q  <= '0;
            end
         end else if (arrived) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            total_q <= cnt_q;
         end else begin
            cur_q <= sel_nxt;
            cnt_q <= cnt_q + CNT_W'(1);
            if (is_se && se_adv) ph_q <= ph_q + PH_W'(1);
         end
      end
   end

   assign busy       = busy_q;
   assign cur_addr   = cur_q;
   assign step_code  = (busy_q && !arrived) ? sel_code : STEP_NONE;
   assign done       = done_q;
   assign step_total = total_q;
endmodule

// File: rtl/sx_route_chk.sv
module sx_route_chk #(
   parameter int ADDR_W = 3,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [ADDR_W-1:0] dst_q,
   input logic [2:0]        step_code,
   input logic [CNT_W-1:0]  step_total
);
   // R3
   step_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_code != 3'd0) |-> busy);

   // R4
   exch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step_code == 3'd2) |=> (cur_addr == ($past(cur_addr) ^ ADDR_W'(1))));

   // R4
   shuf_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step_code == 3'd1) |=>
         (cur_addr == {$past(cur_addr[ADDR_W-2:0]), $past(cur_addr[ADDR_W-1])}));

   // R5
   done_at_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cur_addr == dst_q));

   // R5
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(step_total) <= 2 * ADDR_W - 1));

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(cur_addr));
endmodule

bind sx_route sx_route_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .cur_addr(cur_addr), .dst_q(dst_q), .step_code(step_code),
   .step_total(step_total)
);

// File: tb/sim_sx_route.sv
`timescale 1ns/1ps
module sim_sx_route;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [1:0]    mode;
   logic [AW-1:0] src;
   logic [AW-1:0] dst;
   logic          busy;
   logic [AW-1:0] cur_addr;
   logic [2:0]    step_code;
   logic          done;
   logic [2:0]    step_total;

   int total = 0;
   int bad   = 0;
   int tr_code [64];
   int tr_addr [64];

   always #2 clk = ~clk;

   sx_route #(.ADDR_W(AW), .PM_SIGNED(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .src(src), .dst(dst),
      .busy(busy), .cur_addr(cur_addr), .step_code(step_code), .done(done),
      .step_total(step_total)
   );

   // {mode, src, dst, expected count}
   localparam logic [10:0] VEC [8] = '{
      {2'd0, 3'd0, 3'd7, 3'd5},   // R6
      {2'd0, 3'd5, 3'd5, 3'd0},   // R7
      {2'd0, 3'd7, 3'd0, 3'd5},   // R5
      {2'd3, 3'd0, 3'd7, 3'd5},   // R5 spare code
      {2'd1, 3'd0, 3'd7, 3'd3},   // R8
      {2'd1, 3'd2, 3'd3, 3'd1},   // R8
      {2'd2, 3'd0, 3'd4, 3'd1},   // R9
      {2'd2, 3'd1, 3'd0, 3'd1}    // R9 subtract
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Launches at the current negedge and returns at the negedge where done is high.
   task automatic run(input logic [1:0] m, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      output int tot, output int fin, output int nst);
      int cyc;
      mode = m; src = s; dst = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && cur_addr == s, "R2", "launch busy/cur", int'(cur_addr), int'(s));
      nst = 0; cyc = 0;
      while (!done && cyc < 60) begin
         if (step_code != 3'd0) begin
            tr_code[nst] = int'(step_code);
            @(negedge clk);
            tr_addr[nst] = int'(cur_addr);
            nst++;
         end else begin
            @(negedge clk);
         end
         cyc++;
      end
      check(done == 1'b1, "R10", "route finished", int'(done), 1);
      tot = int'(step_total);
      fin = int'(cur_addr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int tot, fin, nst;
      rst_n = 1'b0; start = 1'b0; mode = 2'd0; src = '0; dst = '0;
      repeat (3) @(negedge clk);
      // R1
      check(!busy && !done && cur_addr == 0 && step_code == 0 && step_total == 0,
            "R1", "reset outputs", int'({busy, done, cur_addr, step_code, step_total}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && cur_addr == 0, "R1", "after release",
            int'({busy, done, cur_addr}), 0);

      // directed table
      for (int i = 0; i < 8; i++) begin
         run(VEC[i][10:9], VEC[i][8:6], VEC[i][5:3], tot, fin, nst);
         check(tot == int'(VEC[i][2:0]), "R5/R7/R8/R9", $sformatf("table %0d count", i),
               tot, int'(VEC[i][2:0]));
         check(fin == int'(VEC[i][5:3]), "R5", $sformatf("table %0d final", i),
               fin, int'(VEC[i][5:3]));
         check(!busy, "R10", "busy low with done", int'(busy), 0);
      end

      // sweep of every pair in every mode, each launched in the prior done cycle
      for (int m = 0; m < 3; m++) begin
         for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
               run(2'(m), 3'(s), 3'(d), tot, fin, nst);
               check(fin == d, "R5/R8/R9", $sformatf("m%0d %0d->%0d final", m, s, d), fin, d);
               check(nst == tot, "R3", $sformatf("m%0d %0d->%0d coded cycles", m, s, d), nst, tot);
               if (m == 0)
                  check(tot <= 2 * AW - 1, "R5", "shex bound", tot, 2 * AW - 1);
               else if (m == 1)
                  check(tot == $countones(3'(s ^ d)), "R8", "cube count",
                        tot, $countones(3'(s ^ d)));
               else begin
                  check(tot <= AW, "R9", "pm bound", tot, AW);
                  for (int k = 0; k < nst; k++)
                     check(tr_code[k] == 4 || tr_code[k] == 5, "R9", "pm code", tr_code[k], 4);
               end
               if (s == d) check(tot == 0, "R7", "same address count", tot, 0);
            end
         end
      end

      // R6 and R4: exact trace from all zeros to all ones
      run(2'd0, 3'd0, 3'd7, tot, fin, nst);
      check(nst == 5, "R6", "step count", nst, 5);
      for (int k = 0; k < 5; k++) begin
         int ec;
         int ea;
         ec = (k % 2 == 0) ? 2 : 1;
         ea = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 6 : 7;
         check(tr_code[k] == ec, "R6", $sformatf("code step %0d", k), tr_code[k], ec);
         check(tr_addr[k] == ea, "R4", $sformatf("addr step %0d", k), tr_addr[k], ea);
      end

      // R10: pulse lasts one cycle and count is held
      @(negedge clk);
      check(!done, "R10", "done one cycle", int'(done), 0);
      check(step_total == 5, "R10", "count held", int'(step_total), 5);

      // R2: start during a route is ignored
      mode = 2'd0; src = 3'd0; dst = 3'd7; start = 1'b1;
      @(negedge clk);
      mode = 2'd1; src = 3'd5; dst = 3'd5;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 20 && !done; c++) @(negedge clk);
      check(cur_addr == 7, "R2", "ignored start final", int'(cur_addr), 7);
      check(step_total == 5, "R2", "ignored start count", int'(step_total), 5);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule